// File: doc/BRIEF.md
# Asynchronous Serial Port with Rate Doubler

This block is a full-duplex asynchronous serial port that moves 8-bit characters. Each character travels as a low start bit, then eight data bits with the least significant bit first, then a high stop bit. The block has no baud generator of its own. An external timer supplies a one-cycle overflow pulse on `tick`. The port divides that pulse train by 32 to get the bit rate, or by 16 when `rateDouble` is high.

Software reaches the port through two byte-wide locations, picked by `regSel`:

- **Control (`regSel` = 0).** This location holds the mode field, a receive enable and two completion flags.
- **Data (`regSel` = 1).** A write here starts a transmission. A read returns the last character that was received.

The receiver oversamples the line sixteen times per bit. It decides each bit by a two-of-three vote over the middle samples. It drops a start bit that turns out to be false, and it drops a frame whose stop bit is wrong.

Top module: `async_serial_port`

## Requirements
- R1: After reset, `txd` is 1, the control location reads 0x00 and the data location reads 0x00.
- R2: A write to the data location while the transmitter is idle sends one frame on `txd`. The frame is a start bit of 0, then the eight data bits least significant bit first, then a stop bit of 1. Between frames `txd` stays at 1.
- R3: One bit lasts 32 `tick` pulses while `rateDouble` is 0, and 16 pulses while it is 1. The receiver samples each bit 16 times.
- R4: Transmit-done (control bit 1) becomes 1 when the stop bit starts on `txd`. It stays 1 until software writes the control location with bit 1 cleared.
- R5: A write to the data location while a frame is being sent is ignored. The frame in progress is unchanged and no second frame follows.
- R6: When a valid frame arrives, its byte is readable at the data location and receive-done (control bit 0) becomes 1. The flag stays 1 until software clears it. Each bit value is the majority of oversamples 7, 8 and 9, so a glitch one sample long near mid-bit does not change the byte.
- R7: No reception takes place while receive enable (control bit 4) is 0. Clearing the bit during a frame abandons that frame.
- R8: A falling edge followed by a 1 at the middle of the start bit is treated as noise. The receiver returns to idle, and neither the flag nor the data location changes.
- R9: A frame whose stop bit is sampled as 0 is discarded. The data location and receive-done are left unchanged, and the next valid frame is received normally.
- R10: The other control fields are stored as written and read back unchanged, without affecting the port. These are the mode field (bits 7:6, where 01 is the 8-bit mode), the multiprocessor bit (bit 5) and the two ninth-bit fields (bits 3 and 2). `regSel` = 0 addresses the control location and `regSel` = 1 addresses the data location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle overflow pulse from an external timer |
| rateDouble | input | 1 | 1: bit rate is tick/16, 0: tick/32 |
| regWr | input | 1 | Write strobe for the selected location |
| regSel | input | 1 | 0: control location, 1: data location |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data of the selected location (combinational) |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |

## Verification
Transmission is exercised with several byte values:

- Alternating and asymmetric patterns (0x96, 0x55, 0x2D) show whether the bit order is correct and whether neighbouring bits are separated.
- A frame with a second data write during its third bit shows whether that write is really ignored.

Both divide settings are run. This makes a wrong bit period visible as a shifted transmit-done instant.

Reception is exercised with:

- a clean frame, and one with a glitch at mid-bit;
- a frame sent while disabled;
- a short false start;
- a frame with a bad stop bit, followed by a clean frame.

Taken together, these separate correct voting and abort handling from a receiver that merely copies the line.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam int CTL_W      = 8;
  localparam int CTL_RXDONE = 0;
  localparam int CTL_TXDONE = 1;
  localparam int CTL_RXEN   = 4;

  typedef struct packed {
    logic txLoad;
    logic txShift;
    logic txDoneSet;
    logic rxCapture;
    logic rxShift;
    logic rxAccept;
  } uartStrobesT;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rxStateT;
endpackage

// File: rtl/uart_ctrl.sv
module uart_ctrl
  import uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        rateDouble,
  input  logic        dataWr,
  input  logic        rxEn,
  input  logic        rxFall,
  input  logic        majNow,
  output uartStrobesT stb,
  output logic        txBusy
);
  localparam int PH_W   = $clog2(OVS);
  localparam int FRAME  = DATA_W + 2;
  localparam int TXI_W  = $clog2(FRAME);
  localparam int RXI_W  = $clog2(DATA_W);
  localparam int SMP_A  = OVS / 2 - 1;
  localparam int SMP_C  = OVS / 2 + 1;
  localparam int LAST   = OVS - 1;

  logic halfPh, sampleStb;
  logic [TXI_W-1:0] txIdx;
  logic [PH_W-1:0]  txPh, rxPh;
  logic [RXI_W-1:0] rxIdx;
  rxStateT rxState;
  logic txStart, txWrap, rxMid, rxActive;

  // rate divider: every tick in doubled mode, every second tick otherwise
  always_ff @(posedge clk) begin
    if (!rstN) halfPh <= 1'b0;
    else if (tick) halfPh <= ~halfPh;
  end
  assign sampleStb = tick && (rateDouble || halfPh);

  // transmit sequencing
  assign txStart = dataWr && !txBusy;
  assign txWrap  = txBusy && sampleStb && (txPh == PH_W'(LAST));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy <= 1'b0;
      txIdx  <= '0;
      txPh   <= '0;
    end else if (txStart) begin
      txBusy <= 1'b1;
      txIdx  <= '0;
      txPh   <= '0;
    end else if (txBusy && sampleStb) begin
      txPh <= txPh + 1'b1;
      if (txWrap) begin
        if (txIdx == TXI_W'(FRAME - 1)) txBusy <= 1'b0;
        else txIdx <= txIdx + 1'b1;
      end
    end
  end

  // receive sequencing
  assign rxActive = (rxState != RX_IDLE);
  assign rxMid    = rxActive && sampleStb && (rxPh == PH_W'(SMP_C));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxPh    <= '0;
      rxIdx   <= '0;
    end else if (!rxEn) begin
      rxState <= RX_IDLE;
    end else if (!rxActive) begin
      if (rxFall) begin
        rxState <= RX_START;
        rxPh    <= '0;
        rxIdx   <= '0;
      end
    end else if (sampleStb) begin
      rxPh <= rxPh + 1'b1;
      if (rxMid) begin
        unique case (rxState)
          RX_START: rxState <= majNow ? RX_IDLE : RX_DATA;
          RX_DATA: begin
            rxIdx <= rxIdx + 1'b1;
            if (rxIdx == RXI_W'(DATA_W - 1)) rxState <= RX_STOP;
          end
          default: rxState <= RX_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    stb.txLoad    = txStart;
    stb.txShift   = txWrap && (txIdx != TXI_W'(FRAME - 1));
    stb.txDoneSet = txWrap && (txIdx == TXI_W'(FRAME - 2));
    stb.rxCapture = rxActive && sampleStb &&
                    ((rxPh == PH_W'(SMP_A)) || (rxPh == PH_W'(SMP_A + 1)));
    stb.rxShift   = rxMid && (rxState == RX_DATA);
    stb.rxAccept  = rxMid && (rxState == RX_STOP) && majNow;
  end

  AST_RX_OFF_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !rxEn |=> rxState == RX_IDLE); // R7
  AST_START_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    (rxMid && rxState == RX_START && majNow && rxEn) |=> rxState == RX_IDLE); // R8
  AST_NO_TX_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && dataWr && !txWrap) |=> txBusy); // R5
endmodule

// File: rtl/uart_dp.sv
module uart_dp
  import uart_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ctlWr,
  input  logic             regSel,
  input  logic [CTL_W-1:0] wrData,
  input  uartStrobesT      stb,
  input  logic             rxd,
  output logic             txd,
  output logic [CTL_W-1:0] rdData,
  output logic             rxEn,
  output logic             rxFall,
  output logic             majNow
);
  logic [CTL_W-1:0]  ctl;
  logic [DATA_W+1:0] txSh;
  logic [DATA_W-1:0] rxSh, rxBuf;
  logic sync1, sync2, prevLine;
  logic [1:0] win;

  // control location: software writes, hardware sets the completion flags
  always_ff @(posedge clk) begin
    if (!rstN) ctl <= '0;
    else begin
      if (ctlWr) ctl <= wrData;
      if (stb.txDoneSet) ctl[CTL_TXDONE] <= 1'b1;
      if (stb.rxAccept)  ctl[CTL_RXDONE] <= 1'b1;
    end
  end
  assign rxEn = ctl[CTL_RXEN];

  // transmit shifter: start, data LSB first, stop; fills with idle ones
  always_ff @(posedge clk) begin
    if (!rstN) txSh <= '1;
    else if (stb.txLoad) txSh <= {1'b1, DATA_W'(wrData), 1'b0};
    else if (stb.txShift) txSh <= {1'b1, txSh[DATA_W+1:1]};
  end
  assign txd = txSh[0];

  // receive line synchroniser, edge detect and vote window
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sync1    <= 1'b1;
      sync2    <= 1'b1;
      prevLine <= 1'b1;
      win      <= 2'b11;
    end else begin
      sync1    <= rxd;
      sync2    <= sync1;
      prevLine <= sync2;
      if (stb.rxCapture) win <= {win[0], sync2};
    end
  end
  assign rxFall = prevLine && !sync2;
  assign majNow = (win[1] & win[0]) | (win[1] & sync2) | (win[0] & sync2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSh  <= '0;
      rxBuf <= '0;
    end else begin
      if (stb.rxShift)  rxSh  <= {majNow, rxSh[DATA_W-1:1]};
      if (stb.rxAccept) rxBuf <= rxSh;
    end
  end

  assign rdData = regSel ? CTL_W'(rxBuf) : ctl;

  AST_TXDONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ctl[CTL_TXDONE] && !ctlWr) |=> ctl[CTL_TXDONE]); // R4
  AST_RXDONE_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (ctl[CTL_RXDONE] && !ctlWr) |=> ctl[CTL_RXDONE]); // R6
  AST_BUF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rxAccept |=> $stable(rxBuf)); // R9
endmodule

// File: rtl/async_serial_port.sv
module async_serial_port
  import uart_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       rateDouble,
  input  logic       regWr,
  input  logic       regSel,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       rxd,
  output logic       txd
);
  uartStrobesT stb;
  logic txBusy, rxEn, rxFall, majNow;

  uart_ctrl #(.DATA_W(DATA_W), .OVS(OVS)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .rateDouble(rateDouble),
    .dataWr(regWr && regSel), .rxEn(rxEn), .rxFall(rxFall), .majNow(majNow),
    .stb(stb), .txBusy(txBusy)
  );

  uart_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctlWr(regWr && !regSel), .regSel(regSel),
    .wrData(wrData), .stb(stb), .rxd(rxd), .txd(txd), .rdData(rdData),
    .rxEn(rxEn), .rxFall(rxFall), .majNow(majNow)
  );

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !txBusy |-> txd); // R2
  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> !txd); // R2
  AST_DONE_WITH_STOP: assert property (@(posedge clk) disable iff (!rstN)
    stb.txDoneSet |=> txd); // R4
endmodule

// File: tb/async_serial_port_tb.sv
module async_serial_port_tb;
  localparam int TICK_GAP = 3;

  logic clk = 1'b0, rstN = 1'b0, tick = 1'b0, rateDouble = 1'b0;
  logic regWr = 1'b0, regSel = 1'b0, rxd = 1'b1;
  logic [7:0] wrData = 8'h00;
  wire  [7:0] rdData;
  wire        txd;
  int errors = 0, checks = 0, bitClk = 0;
  logic [7:0] expCtl, expBuf, rv;

  async_serial_port u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .rateDouble(rateDouble),
    .regWr(regWr), .regSel(regSel), .wrData(wrData), .rdData(rdData),
    .rxd(rxd), .txd(txd)
  );

  always #4 clk = ~clk;

  initial begin
    int c;
    c = 0;
    forever begin
      @(negedge clk);
      c = (c + 1) % TICK_GAP;
      tick = (c == 0);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkRange(input string req, input int act, input int lo, input int hi);
    checks++;
    if (act < lo || act > hi) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic setRate(input logic dbl);
    rateDouble = dbl;
    bitClk = 16 * TICK_GAP * (dbl ? 1 : 2);
  endtask

  task automatic readReg(input logic sel, output logic [7:0] v);
    @(negedge clk);
    regSel = sel;
    #1 v = rdData;
  endtask

  task automatic writeReg(input logic sel, input logic [7:0] val);
    @(negedge clk);
    regWr = 1'b1; regSel = sel; wrData = val;
    @(negedge clk);
    regWr = 1'b0; regSel = 1'b0;
  endtask

  // expected: frame shape, transmit-done instant (9 bit times after start), idle after
  task automatic sendTx(input logic [7:0] val, input logic midWrite);
    int doneAt, zeros, s;
    logic [9:0] got;
    s = bitClk / 16;
    doneAt = -1; zeros = 0; got = '0;
    writeReg(1'b1, val);
    for (int n = 0; n <= 10 * bitClk; n++) begin
      if (n > 0) @(negedge clk);
      if (midWrite && n == 3 * bitClk) begin
        regWr = 1'b1; regSel = 1'b1; wrData = 8'h00;
      end else begin
        regWr = 1'b0; regSel = 1'b0;
      end
      #1;
      if (n % bitClk == bitClk / 2) got[n / bitClk] = txd;
      if (!(midWrite && n == 3 * bitClk) && doneAt < 0 && rdData[1]) doneAt = n;
    end
    check("R2 frame bits", int'(got), int'({1'b1, val, 1'b0}));
    checkRange("R3/R4 transmit-done instant", doneAt, 9 * bitClk - s, 9 * bitClk + 1);
    for (int n = 0; n < 2 * bitClk; n++) begin
      @(negedge clk);
      if (txd !== 1'b1) zeros++;
    end
    check(midWrite ? "R5 no second frame" : "R2 idle after frame", zeros, 0);
  endtask

  task automatic sendRx(input logic [7:0] val, input logic stopV, input int glitchBit);
    logic [9:0] fr;
    logic v;
    int s;
    s = bitClk / 16;
    fr = {stopV, val, 1'b0};
    for (int k = 0; k < 10; k++) begin
      for (int c = 0; c < bitClk; c++) begin
        @(negedge clk);
        v = fr[k];
        if (k == glitchBit + 1 && c >= 8 * s && c < 9 * s) v = ~v;
        rxd = v;
      end
    end
    @(negedge clk);
    rxd = 1'b1;
    repeat (bitClk) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    setRate(1'b0);
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    expCtl = 8'h00; expBuf = 8'h00;

    // R1 reset state
    readReg(1'b0, rv); check("R1 control reset", rv, 8'h00);
    readReg(1'b1, rv); check("R1 data reset", rv, 8'h00);
    check("R1 txd idle", txd, 1);

    // R7 disabled receiver ignores a frame
    sendRx(8'hA5, 1'b1, -1);
    readReg(1'b0, rv); check("R7 no flag when disabled", rv, expCtl);
    readReg(1'b1, rv); check("R7 buffer untouched", rv, expBuf);

    // R10 enable receiver, mode 01
    writeReg(1'b0, 8'h50); expCtl = 8'h50;
    readReg(1'b0, rv); check("R10 control readback", rv, expCtl);

    // R6 clean frame
    sendRx(8'h3C, 1'b1, -1); expBuf = 8'h3C; expCtl = 8'h51;
    readReg(1'b1, rv); check("R6 received byte", rv, expBuf);
    readReg(1'b0, rv); check("R6 receive-done set", rv, expCtl);
    repeat (bitClk) @(negedge clk);
    readReg(1'b0, rv); check("R6 receive-done sticky", rv, expCtl);
    writeReg(1'b0, 8'h50); expCtl = 8'h50;
    readReg(1'b0, rv); check("R6 receive-done cleared", rv, expCtl);

    // R6 glitch at mid-bit of data bit 2
    sendRx(8'hC3, 1'b1, 2); expBuf = 8'hC3; expCtl = 8'h51;
    readReg(1'b1, rv); check("R6 majority vote byte", rv, expBuf);
    readReg(1'b0, rv); check("R6 flag after glitch frame", rv, expCtl);
    writeReg(1'b0, 8'h50); expCtl = 8'h50;

    // R8 false start
    @(negedge clk); rxd = 1'b0;
    repeat (3 * (bitClk / 16)) @(negedge clk);
    rxd = 1'b1;
    repeat (2 * bitClk) @(negedge clk);
    readReg(1'b0, rv); check("R8 false start no flag", rv, expCtl);
    readReg(1'b1, rv); check("R8 false start buffer", rv, expBuf);

    // R9 framing error then recovery
    sendRx(8'h81, 1'b0, -1);
    readReg(1'b0, rv); check("R9 bad stop no flag", rv, expCtl);
    readReg(1'b1, rv); check("R9 bad stop buffer kept", rv, expBuf);
    sendRx(8'h7E, 1'b1, -1); expBuf = 8'h7E; expCtl = 8'h51;
    readReg(1'b1, rv); check("R9 recovery byte", rv, expBuf);
    writeReg(1'b0, 8'h50); expCtl = 8'h50;

    // R2 R3 R4 transmit
    sendTx(8'h96, 1'b0); expCtl = 8'h52;
    readReg(1'b0, rv); check("R4 transmit-done set", rv, expCtl);
    repeat (bitClk) @(negedge clk);
    readReg(1'b0, rv); check("R4 transmit-done sticky", rv, expCtl);
    writeReg(1'b0, 8'h50); expCtl = 8'h50;
    readReg(1'b0, rv); check("R4 transmit-done cleared", rv, expCtl);

    // R5 write during transmission
    sendTx(8'h0F, 1'b1); expCtl = 8'h52;
    readReg(1'b0, rv); check("R5 flag after ignored write", rv, expCtl);

    // R10 other fields stored, no effect on transmit
    writeReg(1'b0, 8'hEC); expCtl = 8'hEC;
    readReg(1'b0, rv); check("R10 fields readback", rv, expCtl);
    sendTx(8'h55, 1'b0); expCtl = 8'hEE;
    readReg(1'b0, rv); check("R10 fields kept with flag", rv, expCtl);
    readReg(1'b1, rv); check("R10 data location select", rv, expBuf);

    // R3 doubled rate
    setRate(1'b1);
    writeReg(1'b0, 8'h50); expCtl = 8'h50;
    sendRx(8'hB4, 1'b1, -1); expBuf = 8'hB4; expCtl = 8'h51;
    readReg(1'b1, rv); check("R3 doubled receive byte", rv, expBuf);
    writeReg(1'b0, 8'h50); expCtl = 8'h50;
    sendTx(8'h2D, 1'b0); expCtl = 8'h52;
    readReg(1'b0, rv); check("R3 doubled transmit flag", rv, expCtl);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule